// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block derives the bit-rate timing for a three-wire serial master from the functional clock. Two dividers sit in series. The first stage is shared by the whole interface and divides by 2, 4, 7 or 10. The odd ratio gives a single-cycle pulse, so its duty cycle is not even. The second stage takes its setting from the currently selected peripheral and counts first-stage pulses. Its ratio is 2, 4 or 8.

The second stage splits every serial period into two halves. At the end of the first half it raises a leading-edge strobe, which the shift engine uses to drive data. At the end of the period it raises a trailing-edge strobe, which doubles as the bit tick used for sampling. A level output follows the same phases and gives the serial clock pin. A polarity input flips that level, including its idle value.

A global run input gates the whole chain. Removing it clears both counters and parks the clock at its idle level. A change of either ratio code also restarts both counters, so a period is never cut short or stretched.

Top module: `sclk_prescaler`

## Requirements
- R1: While reset is high and on the first cycle after it, `bit_tick` and `lead_stb` are 0, and `sclk_out` equals `clk_inv`.
- R2: While `clk_en` is 0, no strobe is produced. From the cycle after `clk_en` falls, `sclk_out` rests at its idle level, which equals `clk_inv`.
- R3: `pre_sel` picks the first-stage ratio N1 as follows: code 0 is 2, code 1 is 4, code 2 is 7 and code 3 is 10.
- R4: `post_sel` picks the second-stage ratio N2 as follows: code 0 is 2, code 1 is 4, and codes 2 and 3 are both 8.
- R5: With a steady configuration, `bit_tick` is a one-cycle pulse that repeats every N1*N2 functional clock cycles.
- R6: `lead_stb` is a one-cycle pulse placed N1*N2/2 cycles after each `bit_tick`. The two strobes are never high together, and they alternate.
- R7: `sclk_out` xor `clk_inv` is 1 from the `lead_stb` cycle up to the cycle before the next `bit_tick`, and 0 otherwise. `clk_inv` = 1 therefore flips the whole waveform.
- R8: When `pre_sel` or `post_sel` changes, both counters restart. Counting from the first clock edge after the change as edge 1, no strobe is produced until `lead_stb` appears after edge N1*N2/2+1 and `bit_tick` appears after edge N1*N2+1.
- R9: When `clk_en` rises with a steady configuration, the first `lead_stb` appears after edge N1*N2/2 and the first `bit_tick` appears after edge N1*N2, counting the first enabled edge as edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Global interface clock enable |
| pre_sel | input | 2 | First-stage ratio code |
| post_sel | input | 2 | Second-stage ratio code for the active select |
| clk_inv | input | 1 | Serial clock polarity invert |
| bit_tick | output | 1 | Trailing-edge strobe, one per serial bit |
| lead_stb | output | 1 | Leading-edge strobe at mid-period |
| sclk_out | output | 1 | Serial clock level |

## Verification
The assertions check the invariants that hold on every cycle. The strobes never overlap and a tick never repeats on back-to-back cycles. No strobe follows a disabled cycle or a ratio change. The clock level matches the phase whenever a strobe fires. Only the bench scenarios can show the exact counts: the full period for every pair of ratio codes, including the odd divide-by-7 and the aliased second-stage code 3, the mid-period position of the leading strobe, and the one-cycle restart offset after a configuration change compared with a fresh enable.

// File: rtl/sclk_prescale_pkg.sv
package sclk_prescale_pkg;

    localparam int PRE_W  = 4;   // holds first-stage terminal count (max 9)
    localparam int POST_W = 3;   // holds second-stage terminal count (max 7)

    typedef enum logic [1:0] {
        PRE_DIV2  = 2'd0,
        PRE_DIV4  = 2'd1,
        PRE_DIV7  = 2'd2,
        PRE_DIV10 = 2'd3
    } pre_code_e;

    typedef enum logic [1:0] {
        POST_DIV2  = 2'd0,
        POST_DIV4  = 2'd1,
        POST_DIV8  = 2'd2,
        POST_DIV8X = 2'd3
    } post_code_e;

    typedef struct packed {
        pre_code_e  pre;
        post_code_e post;
    } div_cfg_t;

    // terminal count (ratio - 1) of the first stage
    function automatic logic [PRE_W-1:0] pre_last(pre_code_e c);
        case (c)
            PRE_DIV2:  return PRE_W'(1);
            PRE_DIV4:  return PRE_W'(3);
            PRE_DIV7:  return PRE_W'(6);
            default:   return PRE_W'(9);
        endcase
    endfunction

    // terminal count of the second stage; the spare code aliases divide by 8
    function automatic logic [POST_W-1:0] post_last(post_code_e c);
        case (c)
            POST_DIV2: return POST_W'(1);
            POST_DIV4: return POST_W'(3);
            default:   return POST_W'(7);
        endcase
    endfunction

    // count at which the first half period ends
    function automatic logic [POST_W-1:0] post_half(post_code_e c);
        case (c)
            POST_DIV2: return POST_W'(0);
            POST_DIV4: return POST_W'(1);
            default:   return POST_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/sclk_pre_divider.sv
module sclk_pre_divider #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] last,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    assign tick = run && !restart && (cnt == last);
endmodule

// File: rtl/sclk_post_divider.sv
module sclk_post_divider #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] last,
    input  logic [W-1:0] half,
    output logic         lead_hit,
    output logic         trail_hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == last) ? '0 : cnt + W'(1);
        end
    end

    assign lead_hit  = step && (cnt == half);
    assign trail_hit = step && (cnt == last);
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
    import sclk_prescale_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic [1:0] pre_sel,
    input  logic [1:0] post_sel,
    input  logic       clk_inv,
    output logic       bit_tick,
    output logic       lead_stb,
    output logic       sclk_out
);
    div_cfg_t cfg_now, cfg_q;
    logic     restart;
    logic     pre_tick, lead_hit, trail_hit;
    logic     lead_q, trail_q, level_q;

    assign cfg_now = '{pre: pre_code_e'(pre_sel), post: post_code_e'(post_sel)};
    assign restart = (cfg_now != cfg_q);

    sclk_pre_divider #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (clk_en),
        .restart (restart),
        .last    (pre_last(cfg_now.pre)),
        .tick    (pre_tick)
    );

    sclk_post_divider #(.W(POST_W)) u_post (
        .clk       (clk),
        .rst       (rst),
        .run       (clk_en),
        .restart   (restart),
        .step      (pre_tick),
        .last      (post_last(cfg_now.post)),
        .half      (post_half(cfg_now.post)),
        .lead_hit  (lead_hit),
        .trail_hit (trail_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{pre: PRE_DIV2, post: POST_DIV2};
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            level_q <= 1'b0;
        end else begin
            cfg_q <= cfg_now;
            if (!clk_en || restart) begin
                lead_q  <= 1'b0;
                trail_q <= 1'b0;
                level_q <= 1'b0;
            end else begin
                lead_q  <= lead_hit;
                trail_q <= trail_hit;
                if (lead_hit) begin
                    level_q <= 1'b1;
                end else if (trail_hit) begin
                    level_q <= 1'b0;
                end
            end
        end
    end

    assign bit_tick = trail_q;
    assign lead_stb = lead_q;
    assign sclk_out = level_q ^ clk_inv;
endmodule

// File: rtl/sclk_prescaler_chk.sv
module sclk_prescaler_chk (
    input logic       clk,
    input logic       rst,
    input logic       clk_en,
    input logic [1:0] pre_sel,
    input logic [1:0] post_sel,
    input logic       clk_inv,
    input logic       bit_tick,
    input logic       lead_stb,
    input logic       sclk_out
);
    assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (rst)
        !(bit_tick && lead_stb));

    assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> (!bit_tick && !lead_stb && (sclk_out == clk_inv)));

    assert_level_on_lead_R7: assert property (@(posedge clk) disable iff (rst)
        lead_stb |-> (sclk_out != clk_inv));

    assert_level_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (sclk_out == clk_inv));

    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ((pre_sel != $past(pre_sel)) || (post_sel != $past(post_sel)))
            |=> (!bit_tick && !lead_stb));
endmodule

bind sclk_prescaler sclk_prescaler_chk u_chk (.*);

// File: tb/sim_sclk_prescaler.sv
`timescale 1ns/1ps
module sim_sclk_prescaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [1:0] post_sel = 2'd0;
    logic       clk_inv = 1'b0;
    logic       bit_tick, lead_stb, sclk_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sclk_prescaler u0 (.*);

    // {pre code, post code, N1*N2}
    localparam logic [11:0] VEC [8] = '{
        {2'd1, 2'd0, 8'd8},
        {2'd2, 2'd0, 8'd14},
        {2'd3, 2'd0, 8'd20},
        {2'd0, 2'd1, 8'd8},
        {2'd2, 2'd1, 8'd28},
        {2'd3, 2'd2, 8'd80},
        {2'd2, 2'd3, 8'd56},
        {2'd0, 2'd0, 8'd4}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts negedges until bit_tick; records where lead_stb appeared
    // and the sclk phase seen on the lead and tick cycles
    task automatic measure(output int t_at, output int l_at,
                           output int lvl_lead, output int lvl_tick);
        t_at = -1; l_at = -1; lvl_lead = -1; lvl_tick = -1;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            if (lead_stb && l_at < 0) begin
                l_at = i;
                lvl_lead = int'(sclk_out ^ clk_inv);
            end
            if (bit_tick) begin
                t_at = i;
                lvl_tick = int'(sclk_out ^ clk_inv);
                break;
            end
        end
    endtask

    initial begin
        int t, l, vl, vt, seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick in reset", int'(bit_tick), 0);
        check("R1 lead in reset", int'(lead_stb), 0);
        check("R1 sclk in reset", int'(sclk_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tick after reset", int'(bit_tick), 0);

        // R2: disabled, no strobes; idle level follows the invert input
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (bit_tick || lead_stb) seen++;
        end
        check("R2 strobes while off", seen, 0);
        clk_inv = 1'b1;
        #1;
        check("R2 idle level inverted", int'(sclk_out), 1);
        clk_inv = 1'b0;
        #1;
        check("R2 idle level normal", int'(sclk_out), 0);

        // R9: fresh enable with codes 0/0 (N=4)
        clk_en = 1'b1;
        measure(t, l, vl, vt);
        check("R9 first tick after enable", t, 4);
        check("R9 first lead after enable", l, 2);

        // R3 R4 R5 R6 R7 R8: table walk, each entry is a config change
        for (int k = 0; k < 8; k++) begin
            int n;
            n = int'(VEC[k][7:0]);
            pre_sel  = VEC[k][11:10];
            post_sel = VEC[k][9:8];
            measure(t, l, vl, vt);
            check("R8 first tick after change", t, n + 1);
            check("R8 first lead after change", l, n / 2 + 1);
            measure(t, l, vl, vt);
            check("R5 R3 R4 steady period", t, n);
            check("R6 lead at mid period", l, n / 2);
            check("R7 level at lead", vl, 1);
            check("R7 level at tick", vt, 0);
        end

        // R7: inverted polarity keeps timing, flips level
        clk_inv = 1'b1;
        measure(t, l, vl, vt);
        measure(t, l, vl, vt);
        check("R7 inverted period", t, 4);
        check("R7 inverted level at lead", int'(vl), 1);
        check("R7 inverted raw sclk idle", int'(sclk_out), 1);
        clk_inv = 1'b0;

        // R8: change in mid period with divide-by-7 then back
        pre_sel = 2'd2; post_sel = 2'd2;   // N = 56
        measure(t, l, vl, vt);
        repeat (10) @(negedge clk);
        post_sel = 2'd1;                    // N = 28
        measure(t, l, vl, vt);
        check("R8 mid-period restart tick", t, 29);
        check("R8 mid-period restart lead", l, 15);

        // R2: dropping enable mid period silences the outputs
        repeat (5) @(negedge clk);
        clk_en = 1'b0;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (bit_tick || lead_stb || sclk_out) seen++;
        end
        check("R2 quiet after disable", seen, 0);

        // R9: re-enable restarts a full period
        clk_en = 1'b1;
        measure(t, l, vl, vt);
        check("R9 re-enable tick", t, 28);
        check("R9 re-enable lead", l, 14);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule